// File: doc/BRIEF.md
# Timecode Frame Sequencer

This block sets the frame-level pace of a linear timecode transmitter and receiver. Each frame is 80 bit times long. On the transmit side, software writes 64 bits of frame data into a holding register. At a fixed bit time in each frame, the block copies that register into a next-frame register and raises a one-cycle transmit event. At the frame boundary the next-frame register becomes the live frame that the serializer shifts out. Because there are two buffer stages, data written after a frame's transmit event goes out two frames later.

On the receive side, the block looks for the 16-bit sync word in the forward bit stream. It then collects the 64 data bits that follow. After the last data bit it latches the whole frame into a readable register and raises a receive event. A 10-bit interval timer counts strobes from one of three selectable sources and produces a one-cycle event each time it expires. All bit and tick strobes are single-cycle enables that are synchronous to the system clock.

Top module: `ltc_frame_seq`

## Requirements
- R1: After synchronous reset, the transmit bit index is 0 and every frame register, the received frame and all three event outputs are 0.
- R2: The transmit bit index advances by one on each `tx_bit_stb`, runs 0 to 79, and returns to 0 on the strobe taken at index 79.
- R3: A `tx_bit_stb` taken at index 71 (the end of the 72nd bit time) with `tx_en` high copies the holding register into `tx_next_frame` and pulses `tx_xfer_evt` high for exactly the following cycle. No other strobe produces the event.
- R4: While `tx_en` is low, the bit-72 strobe leaves `tx_next_frame` unchanged and raises no event.
- R5: The strobe at index 79 loads `tx_next_frame` into `tx_live_frame`. Data written before frame N's transmit event is live in frame N+1; data written after it is live in frame N+2.
- R6: After the 16-bit sync word 16'h3FFD has been received (first received bit = MSB) on forward strobes, the 64th following forward bit latches those 64 bits into `rx_frame` (data bit k, counted from 0 in arrival order, at `rx_frame[k]`) and pulses `rx_evt` for one cycle. Nothing happens at the 63rd bit.
- R7: Without a preceding sync word, 64 bits raise no event and leave `rx_frame` unchanged. Each event consumes its sync, so the next frame needs a new one.
- R8: A receive strobe with `rx_fwd` low discards any partly received frame. No event follows until a new sync word has arrived.
- R9: With `tmr_sel` 0 = 100 kHz tick, 1 = receive bit strobe, 2 = transmit bit strobe, the enabled timer raises a one-cycle `tmr_evt` after every `tmr_tc`+1 strobes of the selected source.
- R10: `tmr_sel` = 3 selects no source. While `tmr_en` is low the timer raises no event and its count returns to zero.
- R11: Strobes from a source other than the selected one do not advance the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_bit_stb | input | 1 | One-cycle strobe per transmitted bit time |
| tx_en | input | 1 | Enables the holding-to-next-frame transfer |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | 64 | Frame data written by software |
| tx_bit_idx | output | 7 | Current transmit bit position, 0..79 |
| tx_next_frame | output | 64 | Frame queued for the next frame period |
| tx_live_frame | output | 64 | Frame being serialized now |
| tx_xfer_evt | output | 1 | Transmit transfer event pulse |
| rx_bit_stb | input | 1 | One-cycle strobe per received bit |
| rx_bit | input | 1 | Received bit value |
| rx_fwd | input | 1 | High when the received bit runs in the forward direction |
| rx_frame | output | 64 | Last complete received frame |
| rx_evt | output | 1 | Receive frame event pulse |
| tick_100k | input | 1 | 100 kHz timebase strobe |
| tmr_en | input | 1 | Interval timer enable |
| tmr_sel | input | 2 | Timer source select |
| tmr_tc | input | 10 | Timer terminal count |
| tmr_evt | output | 1 | Timer expiry pulse |

## Verification
The assertions check on every cycle the rules that hold between adjacent cycles. The bit index stays in range and wraps at 79. A transmit event appears only after an enabled bit-72 strobe. The next-frame register moves only on that strobe. The received frame changes only alongside its event. A timer event is always preceded by a strobe from the selected source. The frame-level behaviour spans whole frames, so only the bench scenarios show it: the N+1 versus N+2 placement of written data, sync gating and direction reversal on the receive side, and timer periods for each source and terminal count.

// File: rtl/ltc_seq_pkg.sv
package ltc_seq_pkg;

    localparam int FRAME_BITS = 80;
    localparam int DATA_BITS  = 64;
    localparam int SYNC_BITS  = 16;
    localparam int XFER_BIT   = 72;
    localparam int TMR_W      = 10;
    localparam logic [15:0] SYNC_WORD = 16'h3FFD;

    typedef enum logic [1:0] {
        SRC_100K = 2'd0,
        SRC_RXBIT = 2'd1,
        SRC_TXBIT = 2'd2,
        SRC_NONE = 2'd3
    } tmr_src_e;

    function automatic logic pick_tick(tmr_src_e sel, logic t100k, logic trx, logic ttx);
        logic r;
        case (sel)
            SRC_100K:  r = t100k;
            SRC_RXBIT: r = trx;
            SRC_TXBIT: r = ttx;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ltc_tx_seq.sv
module ltc_tx_seq
    import ltc_seq_pkg::*;
#(
    parameter int FB   = FRAME_BITS,
    parameter int DB   = DATA_BITS,
    parameter int XB   = XFER_BIT,
    localparam int IW  = $clog2(FB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_stb,
    input  logic          en,
    input  logic          wr,
    input  logic [DB-1:0] wdata,
    output logic [IW-1:0] idx,
    output logic [DB-1:0] next_frame,
    output logic [DB-1:0] live_frame,
    output logic          evt
);
    localparam logic [IW-1:0] LAST_IDX = IW'(FB - 1);
    localparam logic [IW-1:0] XFER_IDX = IW'(XB - 1);

    logic [DB-1:0] hold_q;
    logic          at_end;
    logic          at_xfer;

    assign at_end  = (idx == LAST_IDX);
    assign at_xfer = (idx == XFER_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx        <= '0;
            hold_q     <= '0;
            next_frame <= '0;
            live_frame <= '0;
            evt        <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (wr) begin
                hold_q <= wdata;
            end
            if (bit_stb) begin
                idx <= at_end ? '0 : idx + 1'b1;
                if (at_xfer && en) begin
                    next_frame <= hold_q;
                    evt        <= 1'b1;
                end
                if (at_end) begin
                    live_frame <= next_frame;
                end
            end
        end
    end
endmodule

// File: rtl/ltc_rx_cap.sv
module ltc_rx_cap
    import ltc_seq_pkg::*;
#(
    parameter int DB = DATA_BITS,
    parameter int SB = SYNC_BITS,
    parameter logic [SB-1:0] SW = SYNC_WORD[SB-1:0],
    localparam int CW = $clog2(DB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_stb,
    input  logic          bit_val,
    input  logic          fwd,
    output logic [DB-1:0] frame,
    output logic          evt
);
    localparam logic [CW-1:0] LAST_CNT = CW'(DB - 1);

    logic [SB-1:0] sync_sh;
    logic [SB-1:0] sync_nx;
    logic [DB-1:0] data_sh;
    logic [DB-1:0] data_nx;
    logic [CW-1:0] cnt;
    logic          sync_ok;
    logic          match;

    assign sync_nx = {sync_sh[SB-2:0], bit_val};
    assign match   = (sync_nx == SW);
    assign data_nx = {bit_val, data_sh[DB-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_sh <= '0;
            data_sh <= '0;
            cnt     <= '0;
            sync_ok <= 1'b0;
            frame   <= '0;
            evt     <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (bit_stb) begin
                if (!fwd) begin
                    sync_ok <= 1'b0;
                    cnt     <= '0;
                end else begin
                    sync_sh <= sync_nx;
                    if (match) begin
                        sync_ok <= 1'b1;
                        cnt     <= '0;
                    end else if (sync_ok) begin
                        data_sh <= data_nx;
                        if (cnt == LAST_CNT) begin
                            frame   <= data_nx;
                            evt     <= 1'b1;
                            sync_ok <= 1'b0;
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ltc_intv_timer.sv
module ltc_intv_timer
    import ltc_seq_pkg::*;
#(
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [1:0]    sel,
    input  logic [TW-1:0] tc,
    input  logic          t100k,
    input  logic          trx,
    input  logic          ttx,
    output logic          evt
);
    logic [TW-1:0] cnt;
    logic          tick;

    assign tick = pick_tick(tmr_src_e'(sel), t100k, trx, ttx);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            evt <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == tc) begin
                    cnt <= '0;
                    evt <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ltc_frame_seq.sv
module ltc_frame_seq
    import ltc_seq_pkg::*;
#(
    parameter int FB = FRAME_BITS,
    parameter int DB = DATA_BITS,
    parameter int SB = SYNC_BITS,
    parameter int XB = XFER_BIT,
    parameter int TW = TMR_W,
    localparam int IW = $clog2(FB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_bit_stb,
    input  logic          tx_en,
    input  logic          hold_wr,
    input  logic [DB-1:0] hold_data,
    output logic [IW-1:0] tx_bit_idx,
    output logic [DB-1:0] tx_next_frame,
    output logic [DB-1:0] tx_live_frame,
    output logic          tx_xfer_evt,
    input  logic          rx_bit_stb,
    input  logic          rx_bit,
    input  logic          rx_fwd,
    output logic [DB-1:0] rx_frame,
    output logic          rx_evt,
    input  logic          tick_100k,
    input  logic          tmr_en,
    input  logic [1:0]    tmr_sel,
    input  logic [TW-1:0] tmr_tc,
    output logic          tmr_evt
);
    ltc_tx_seq #(.FB(FB), .DB(DB), .XB(XB)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (tx_bit_stb),
        .en         (tx_en),
        .wr         (hold_wr),
        .wdata      (hold_data),
        .idx        (tx_bit_idx),
        .next_frame (tx_next_frame),
        .live_frame (tx_live_frame),
        .evt        (tx_xfer_evt)
    );

    ltc_rx_cap #(.DB(DB), .SB(SB)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (rx_bit_stb),
        .bit_val (rx_bit),
        .fwd     (rx_fwd),
        .frame   (rx_frame),
        .evt     (rx_evt)
    );

    ltc_intv_timer #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .en    (tmr_en),
        .sel   (tmr_sel),
        .tc    (tmr_tc),
        .t100k (tick_100k),
        .trx   (rx_bit_stb),
        .ttx   (tx_bit_stb),
        .evt   (tmr_evt)
    );
endmodule

// File: rtl/ltc_frame_seq_chk.sv
module ltc_frame_seq_chk
    import ltc_seq_pkg::*;
#(
    parameter int FB = FRAME_BITS,
    parameter int DB = DATA_BITS,
    parameter int XB = XFER_BIT,
    localparam int IW = $clog2(FB)
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_bit_stb,
    input logic          tx_en,
    input logic [IW-1:0] tx_bit_idx,
    input logic [DB-1:0] tx_next_frame,
    input logic          tx_xfer_evt,
    input logic          rx_bit_stb,
    input logic [DB-1:0] rx_frame,
    input logic          rx_evt,
    input logic          tick_100k,
    input logic          tmr_en,
    input logic [1:0]    tmr_sel,
    input logic          tmr_evt
);
    localparam logic [IW-1:0] LAST_IDX = IW'(FB - 1);
    localparam logic [IW-1:0] XFER_IDX = IW'(XB - 1);

    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        tx_bit_idx <= LAST_IDX);

    p_idx_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_bit_stb && tx_bit_idx == LAST_IDX) |=> (tx_bit_idx == '0));

    p_xfer_cause_r3: assert property (@(posedge clk) disable iff (rst)
        tx_xfer_evt |-> $past(tx_bit_stb && tx_en && tx_bit_idx == XFER_IDX));

    p_next_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(tx_bit_stb && tx_en && tx_bit_idx == XFER_IDX) |=> $stable(tx_next_frame));

    p_rx_frame_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !rx_evt |=> (rx_evt || $stable(rx_frame)));

    p_rx_single_r6: assert property (@(posedge clk) disable iff (rst)
        rx_evt |=> !rx_evt);

    p_tmr_source_r11: assert property (@(posedge clk) disable iff (rst)
        tmr_evt |-> $past(tmr_en && ((tmr_sel == 2'd0 && tick_100k) ||
                                     (tmr_sel == 2'd1 && rx_bit_stb) ||
                                     (tmr_sel == 2'd2 && tx_bit_stb))));
endmodule

bind ltc_frame_seq ltc_frame_seq_chk #(.FB(FB), .DB(DB), .XB(XB)) u_chk (.*);

// File: tb/ltc_frame_seq_test.sv
`timescale 1ns/1ps
module ltc_frame_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_bit_stb = 0, tx_en = 0, hold_wr = 0;
    logic [63:0] hold_data = '0;
    logic [6:0]  tx_bit_idx;
    logic [63:0] tx_next_frame, tx_live_frame, rx_frame;
    logic        tx_xfer_evt, rx_evt, tmr_evt;
    logic        rx_bit_stb = 0, rx_bit = 0, rx_fwd = 1;
    logic        tick_100k = 0, tmr_en = 0;
    logic [1:0]  tmr_sel = 0;
    logic [9:0]  tmr_tc = 0;

    int n_chk = 0, n_bad = 0;
    int tx_evts, rx_evts, tm_evts;
    bit tx_last_evt, rx_last_evt;

    localparam logic [15:0] SYNC = 16'h3FFD;
    localparam logic [63:0] DA = 64'h1122_3344_5566_7788;
    localparam logic [63:0] DB_ = 64'h99AA_BBCC_DDEE_0102;
    localparam logic [63:0] DC = 64'h0F1E_2D3C_4B5A_6978;
    localparam logic [63:0] D1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] D2 = 64'h5A5A_3C3C_0F0F_A5A5;

    // timer vectors: [31:30] sel, [29:28] driven source, [27:18] tc, [17:8] ticks, [7:0] expected events
    localparam int NV = 8;
    localparam logic [31:0] TVEC [NV] = '{
        {2'd0, 2'd0, 10'd4,    10'd10, 8'd2},
        {2'd1, 2'd1, 10'd2,    10'd9,  8'd3},
        {2'd2, 2'd2, 10'd0,    10'd6,  8'd6},
        {2'd0, 2'd1, 10'd0,    10'd5,  8'd0},
        {2'd2, 2'd0, 10'd1,    10'd4,  8'd0},
        {2'd3, 2'd0, 10'd0,    10'd4,  8'd0},
        {2'd1, 2'd1, 10'd9,    10'd25, 8'd2},
        {2'd0, 2'd0, 10'd1023, 10'd20, 8'd0}
    };

    ltc_frame_seq uut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tx_steps(int n);
        tx_evts = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tx_bit_stb = 1'b1;
            @(negedge clk) tx_bit_stb = 1'b0;
            tx_last_evt = tx_xfer_evt;
            if (tx_xfer_evt) tx_evts++;
        end
    endtask

    task automatic write_hold(logic [63:0] d);
        @(negedge clk);
        hold_wr = 1'b1;
        hold_data = d;
        @(negedge clk);
        hold_wr = 1'b0;
    endtask

    task automatic rx_put(logic b, logic f);
        @(negedge clk);
        rx_bit_stb = 1'b1;
        rx_bit = b;
        rx_fwd = f;
        @(negedge clk);
        rx_bit_stb = 1'b0;
        rx_fwd = 1'b1;
        rx_last_evt = rx_evt;
        if (rx_evt) rx_evts++;
    endtask

    task automatic rx_sync();
        for (int i = 15; i >= 0; i--) rx_put(SYNC[i], 1'b1);
    endtask

    task automatic rx_data(logic [63:0] d, int first, int n);
        for (int k = first; k < first + n; k++) rx_put(d[k], 1'b1);
    endtask

    task automatic tick(int src, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_100k = (src == 0);
            rx_bit_stb = (src == 1);
            tx_bit_stb = (src == 2);
            @(negedge clk);
            tick_100k = 1'b0;
            rx_bit_stb = 1'b0;
            tx_bit_stb = 1'b0;
            if (tmr_evt) tm_evts++;
        end
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(tx_bit_idx == 0, "R1 idx", 64'(tx_bit_idx), 0);
        chk(tx_next_frame == 0 && tx_live_frame == 0, "R1 tx frames", tx_next_frame | tx_live_frame, 0);
        chk(rx_frame == 0, "R1 rx frame", rx_frame, 0);
        chk(!tx_xfer_evt && !rx_evt && !tmr_evt, "R1 events", 64'({tx_xfer_evt, rx_evt, tmr_evt}), 0);

        // timer vector table (R9, R10, R11)
        foreach (TVEC[v]) begin
            @(negedge clk);
            tmr_en = 1'b0;
            tmr_sel = TVEC[v][31:30];
            tmr_tc = TVEC[v][27:18];
            @(negedge clk);
            tmr_en = 1'b1;
            tm_evts = 0;
            tick(int'(TVEC[v][29:28]), int'(TVEC[v][17:8]));
            chk(tm_evts == int'(TVEC[v][7:0]), "R9/R10/R11 timer vector",
                64'(tm_evts), 64'(TVEC[v][7:0]));
        end

        // R10: enable low gives no events and clears the count
        @(negedge clk);
        tmr_en = 1'b0;
        tmr_sel = 2'd0;
        tmr_tc = 10'd3;
        tm_evts = 0;
        tick(0, 6);
        chk(tm_evts == 0, "R10 disabled", 64'(tm_evts), 0);
        tmr_en = 1'b1;
        tick(0, 2);
        @(negedge clk) tmr_en = 1'b0;
        @(negedge clk) tmr_en = 1'b1;
        tick(0, 3);
        chk(tm_evts == 0, "R10 count cleared", 64'(tm_evts), 0);
        tick(0, 1);
        chk(tm_evts == 1, "R9 period after clear", 64'(tm_evts), 1);
        tmr_en = 1'b0;

        // transmit sequencing
        do_reset();
        tx_en = 1'b1;
        write_hold(DA);
        tx_steps(71);
        chk(tx_bit_idx == 71, "R2 idx count", 64'(tx_bit_idx), 71);
        chk(tx_evts == 0 && tx_next_frame == 0, "R3 no early transfer", tx_next_frame, 0);
        tx_steps(1);
        chk(tx_last_evt == 1'b1, "R3 event at bit 72", 64'(tx_last_evt), 1);
        chk(tx_next_frame == DA, "R3 transfer", tx_next_frame, DA);
        chk(tx_live_frame == 0, "R5 live untouched mid-frame", tx_live_frame, 0);
        tx_steps(7);
        chk(tx_bit_idx == 79 && tx_evts == 0, "R2 idx 79", 64'(tx_bit_idx), 79);
        tx_steps(1);
        chk(tx_bit_idx == 0, "R2 wrap", 64'(tx_bit_idx), 0);
        chk(tx_live_frame == DA, "R5 frame N+1", tx_live_frame, DA);
        tx_steps(72);
        chk(tx_evts == 1 && tx_last_evt, "R3 one event per frame", 64'(tx_evts), 1);
        write_hold(DB_);
        tx_steps(8);
        chk(tx_live_frame == DA, "R5 not yet in N+1", tx_live_frame, DA);
        tx_steps(72);
        chk(tx_next_frame == DB_, "R3 second transfer", tx_next_frame, DB_);
        tx_steps(8);
        chk(tx_live_frame == DB_, "R5 frame N+2", tx_live_frame, DB_);
        tx_en = 1'b0;
        write_hold(DC);
        tx_steps(72);
        chk(tx_evts == 0, "R4 no event when disabled", 64'(tx_evts), 0);
        chk(tx_next_frame == DB_, "R4 no transfer", tx_next_frame, DB_);
        tx_steps(8);
        chk(tx_live_frame == DB_, "R4 live unchanged", tx_live_frame, DB_);

        // receive capture
        rx_evts = 0;
        rx_sync();
        rx_data(D1, 0, 63);
        chk(rx_evts == 0, "R6 none at bit 63", 64'(rx_evts), 0);
        rx_data(D1, 63, 1);
        chk(rx_last_evt == 1'b1, "R6 event at bit 64", 64'(rx_last_evt), 1);
        chk(rx_frame == D1, "R6 frame latched", rx_frame, D1);
        rx_evts = 0;
        rx_data(D2, 0, 64);
        chk(rx_evts == 0 && rx_frame == D1, "R7 no sync no event", rx_frame, D1);
        rx_sync();
        rx_data(D2, 0, 30);
        rx_put(1'b0, 1'b0);
        rx_data(D2, 0, 64);
        chk(rx_evts == 0 && rx_frame == D1, "R8 reverse discards", rx_frame, D1);
        rx_sync();
        rx_data(D2, 0, 64);
        chk(rx_evts == 1 && rx_frame == D2, "R6 second frame", rx_frame, D2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule